// File: doc/BRIEF.md
# Sticky Interrupt Request Flag Register

This block holds four interrupt request flags in an 8-bit register that software can read and write. One flag records a pulse from a timer overflow input. The other three record edges on external pins. Each pin first passes through a synchronizer. An edge detector then looks for a rising or a falling edge, chosen per pin. It only detects while that pin's function-enable input is high. Once a flag is set, it stays set. Accepting the interrupt does not clear it. Only a software write of zero to its bit position clears it.

A read returns the four flags at their fixed positions. Two constant-one bits and two constant-zero bits are merged in. A single request output ORs every flag with its per-source enable and is registered. Timer and pin-function logic sit outside the block; their controls arrive as plain inputs.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset all four flags are 0, `rd_data_o` reads 8'h18 and `irq_o` is 0.
- R2: A one-cycle high on `tmr_ovf_i` sampled at a rising clock edge sets register bit 7 at that same edge.
- R3: A level change on `pin_i[k]` (k = 0..2) sets register bit k on the third rising edge after the change, when `pin_func_en_i[k]` is 1 and the change matches `pin_rise_sel_i[k]` (1 = low-to-high, 0 = high-to-low). Bit k is still 0 after the second edge.
- R4: No flag sets for a pin edge while that pin's `pin_func_en_i` bit is 0, or for an edge in the direction that was not selected.
- R5: A cycle with `wr_stb_i` high clears each flag whose bit in `wr_data_i` is 0 (bits 7, 2, 1, 0). A flag whose data bit is 1 keeps its value.
- R6: A set flag stays set, with no time limit, for as long as no clearing write reaches it.
- R7: Read bits 4 and 3 are always 1 and read bits 6 and 5 are always 0. Writes to them have no effect.
- R8: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: `irq_o` equals, one cycle later, the OR over all sources of flag AND enable. `src_en_i[3]` gates bit 7 and `src_en_i[k]` gates bit k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_ovf_i | input | 1 | Timer overflow pulse, one cycle |
| pin_i | input | 3 | Asynchronous external request pins |
| pin_func_en_i | input | 3 | Per-pin enable for edge detection |
| pin_rise_sel_i | input | 3 | Per-pin edge select, 1 = rising, 0 = falling |
| wr_stb_i | input | 1 | Single-cycle register write strobe |
| wr_data_i | input | 8 | Write data; a 0 clears the flag at that position |
| rd_data_o | output | 8 | Flags with constant reserved bits merged |
| src_en_i | input | 4 | Per-source request enables, [3] timer, [2:0] pins |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
Result timing differs by source:
- Timer flag: visible on the read port right after the edge that samples the pulse.
- Clearing write: visible right after the edge that samples the strobe.
- Pin flag: needs three edges after the pin moves, because of two synchronizer flops and the edge-detect register. The bench checks it both after the second edge (still clear) and after the third (set).
- `irq_o`: follows flags and enables by one further edge, and the bench samples it only after that edge.

All inputs are driven and all outputs sampled on the falling clock edge, so each check lands in the exact cycle its result is due.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
   localparam int REG_W    = 8;
   localparam int NUM_PINS = 3;
   localparam int NUM_SRC  = NUM_PINS + 1;
   localparam int TMR_BIT  = 7;
   localparam int TMR_SRC  = NUM_SRC - 1;
   localparam logic [REG_W-1:0] ONES_MASK = 8'h18;

   function automatic logic [REG_W-1:0] place_flags(input logic [NUM_SRC-1:0] f);
      logic [REG_W-1:0] r;
      r = '0;
      r[TMR_BIT] = f[TMR_SRC];
      for (int k = 0; k < NUM_PINS; k++) r[k] = f[k];
      return r;
   endfunction
endpackage

// File: rtl/irqf_pin_edge.sv
module irqf_pin_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic func_en_i,
   input  logic rise_sel_i,
   output logic edge_o
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              lvl;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= pin_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[STAGES-2:0], pin_i};
         end
      end
   endgenerate

   assign lvl = sync_q[STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   always_comb begin
      if (!func_en_i)     edge_o = 1'b0;
      else if (rise_sel_i) edge_o = lvl & ~prev_q;
      else                edge_o = ~lvl & prev_q;
   end
endmodule

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] flags_o
);
   logic [NSRC-1:0] flags_q;

   for (genvar b = 0; b < NSRC; b++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) flags_q[b] <= 1'b0;
         else        flags_q[b] <= set_i[b] | (flags_q[b] & ~clr_i[b]);
      end

      assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> flags_q[b]);
      assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !flags_q[b]);
      assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_q[b] && !clr_i[b]) |=> flags_q[b]);
      assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!flags_q[b] && !set_i[b]) |=> !flags_q[b]);
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/irqf_req_merge.sv
module irqf_req_merge #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] flags_i,
   input  logic [NSRC-1:0] en_i,
   output logic            irq_o
);
   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(flags_i & en_i);
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
   import irqf_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tmr_ovf_i,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic [NUM_PINS-1:0] pin_func_en_i,
   input  logic [NUM_PINS-1:0] pin_rise_sel_i,
   input  logic                wr_stb_i,
   input  logic [REG_W-1:0]    wr_data_i,
   output logic [REG_W-1:0]    rd_data_o,
   input  logic [NUM_SRC-1:0]  src_en_i,
   output logic                irq_o
);
   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (REG_W == 8) else $error("register layout needs 8 bits");
   end

   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] flags;
   logic               unused_wr_bits;

   for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
      irqf_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
         .clk        (clk),
         .rst_n      (rst_n),
         .pin_i      (pin_i[k]),
         .func_en_i  (pin_func_en_i[k]),
         .rise_sel_i (pin_rise_sel_i[k]),
         .edge_o     (set_vec[k])
      );
      assign clr_vec[k] = wr_stb_i & ~wr_data_i[k];
   end

   assign set_vec[TMR_SRC] = tmr_ovf_i;
   assign clr_vec[TMR_SRC] = wr_stb_i & ~wr_data_i[TMR_BIT];
   assign unused_wr_bits   = ^wr_data_i[6:3];

   irqf_flag_bank #(.NSRC(NUM_SRC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .clr_i   (clr_vec),
      .flags_o (flags)
   );

   irqf_req_merge #(.NSRC(NUM_SRC)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flags),
      .en_i    (src_en_i),
      .irq_o   (irq_o)
   );

   assign rd_data_o = place_flags(flags) | ONES_MASK;

   assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[6:3] == 4'b0011);
   assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == $past(|(flags & src_en_i)));
   assert_tmr_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf_i |=> rd_data_o[TMR_BIT]);
endmodule

// File: tb/irq_flag_reg_bench.sv
module irq_flag_reg_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tmr_ovf = 1'b0;
   logic [2:0] pins = 3'b000;
   logic [2:0] fen = 3'b000;
   logic [2:0] rsel = 3'b111;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [3:0] src_en = 4'h0;
   logic       irq;
   int         n_checks = 0;
   int         n_errors = 0;
   int         cyc = 0;

   always #2 clk = ~clk;

   irq_flag_reg u_irq_flag_reg (
      .clk(clk), .rst_n(rst_n), .tmr_ovf_i(tmr_ovf), .pin_i(pins),
      .pin_func_en_i(fen), .pin_rise_sel_i(rsel), .wr_stb_i(wr_stb),
      .wr_data_i(wr_data), .rd_data_o(rd_data), .src_en_i(src_en), .irq_o(irq)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_errors++; n_checks++;
         $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] v);
      wr_stb = 1'b1; wr_data = v;
      tick();
      wr_stb = 1'b0;
   endtask

   // drive every flag to 1 through its normal source
   task automatic set_all();
      fen = 3'b111; rsel = 3'b111; pins = 3'b000;
      tick(4);
      tmr_ovf = 1'b1; pins = 3'b111;
      tick();
      tmr_ovf = 1'b0;
      tick(2);
      pins = 3'b000;
      tick(4);
   endtask

   initial begin
      @(negedge clk);
      tick(2);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 rd_data", rd_data, 8'h18);
      check("R1 irq", {7'b0, irq}, 8'h00);

      // R2 timer flag, R9 registered lag
      src_en = 4'h8;
      tmr_ovf = 1'b1;
      tick();
      tmr_ovf = 1'b0;
      check("R2 timer flag", rd_data, 8'h98);
      check("R9 irq not yet", {7'b0, irq}, 8'h00);
      tick();
      check("R9 irq due", {7'b0, irq}, 8'h01);
      // R6 sticky with no write
      tick(40);
      check("R6 sticky", rd_data, 8'h98);
      check("R6 irq held", {7'b0, irq}, 8'h01);
      src_en = 4'h0;

      // R3/R4 pin edge sweep
      for (int p = 0; p < 3; p++)
         for (int s = 0; s < 2; s++)
            for (int f = 0; f < 2; f++)
               for (int d = 0; d < 2; d++) begin
                  fen = 3'b000;
                  pins = 3'b000;
                  pins[p] = (d == 0);
                  tick(4);
                  reg_write(8'h00);
                  fen[p] = f[0]; rsel[p] = s[0];
                  tick();
                  pins[p] = ~pins[p];
                  tick(2);
                  check("R3 not before third edge", rd_data, 8'h18);
                  tick();
                  if (f == 1 && s == d)
                     check("R3 pin edge sets flag", rd_data, 8'h18 | (8'h01 << p));
                  else
                     check("R4 edge ignored", rd_data, 8'h18);
               end

      // R5/R7 write sweep over every data value
      for (int v = 0; v < 256; v++) begin
         set_all();
         reg_write(v[7:0]);
         check("R5 write clears zeros", rd_data & 8'h87, v[7:0] & 8'h87);
         check("R7 reserved bits", rd_data & 8'h78, 8'h18);
      end

      // R8 timer set against clearing write
      reg_write(8'h00);
      tmr_ovf = 1'b1; wr_stb = 1'b1; wr_data = 8'h00;
      tick();
      tmr_ovf = 1'b0; wr_stb = 1'b0;
      check("R8 timer set wins", rd_data, 8'h98);

      // R8 pin set against clearing write
      reg_write(8'h00);
      fen = 3'b001; rsel = 3'b111; pins = 3'b000;
      tick(4);
      pins = 3'b001;
      tick(2);
      wr_stb = 1'b1; wr_data = 8'h00;
      tick();
      wr_stb = 1'b0;
      check("R8 pin set wins", rd_data, 8'h19);
      pins = 3'b000;
      tick(4);

      // R9 sweep over flag patterns and enables
      for (int fm = 0; fm < 16; fm++)
         for (int en = 0; en < 16; en++) begin
            set_all();
            reg_write({fm[3], 4'b0000, fm[2:0]});
            src_en = en[3:0];
            tick();
            check("R9 combined request", {7'b0, irq}, {7'b0, |(fm[3:0] & en[3:0])});
         end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule